// File: doc/BRIEF.md
# Next Program Counter Unit

This block owns the processor's program counter and works out its next value on each advance. Each cycle the surrounding core presents a decoded control-flow kind, the value of the first register operand, and two offsets: a 16-bit one for conditional branches and a 26-bit one for relative jumps. The core also presents an advance strobe. On a clock edge with the strobe high, the PC moves to the address that the kind selects. On any other edge it keeps its value.

The unit supports seven kinds of step:

- a plain step of one 4-byte instruction;
- a branch taken when the operand is zero;
- a branch taken when the operand is non-zero;
- a relative jump;
- a jump to the address held in the operand;
- a linking version of each of the two jumps.

A linking step offers the address of the following instruction (PC+4) on a link output, together with a write enable meant for register 31. Both come from the PC value before the update, so the register file can capture them on the same edge that moves the PC. All relative targets are measured from PC+4, and all address arithmetic wraps modulo 2^32.

Top module: `pcu_top`

## Requirements
- R1: While `rst` is high the PC is forced to 0 at every clock edge, whatever the other inputs are. The first advance after `rst` is released starts from address 0.
- R2: Kind code 0 is a sequential step and adds 4 to the PC. Code 7 is unused and behaves exactly like code 0.
- R3: On an edge where `adv_i` is low the PC keeps its value, and `link_we_o` stays low, whatever the kind and operands are.
- R4: Kind code 1 (branch on zero) moves the PC to PC+4+sext(`br_ofs_i`) when `rs_val_i` is 0, and to PC+4 otherwise.
- R5: Kind code 2 (branch on non-zero) moves the PC to PC+4+sext(`br_ofs_i`) when `rs_val_i` is not 0, and to PC+4 otherwise.
- R6: Kind code 3 (relative jump) moves the PC to PC+4+sext(`jmp_ofs_i`), where the 26-bit offset is sign-extended from bit 25.
- R7: Kind code 5 (register jump) loads the PC with `rs_val_i` unchanged.
- R8: Kind codes 4 (relative jump with link) and 6 (register jump with link) raise `link_we_o` while `adv_i` is high, with `link_val_o` equal to the PC before the edge plus 4. The PC then moves exactly as it would for code 3 or code 5 respectively.
- R9: For kind codes 0, 1, 2, 3, 5 and 7, `link_we_o` stays low even when `adv_i` is high.
- R10: All next-address arithmetic wraps modulo 2^32. For example, a sequential step from 0xFFFFFFFC gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high, clears the PC |
| adv_i | input | 1 | Advance strobe; the PC updates only on edges where this is high |
| kind_i | input | 3 | Control-flow kind: 0 sequential, 1 branch on zero, 2 branch on non-zero, 3 relative jump, 4 relative jump with link, 5 register jump, 6 register jump with link, 7 unused (treated as sequential) |
| rs_val_i | input | 32 | First register operand, used for the zero test and as the register-jump target |
| br_ofs_i | input | 16 | Signed branch offset in bytes |
| jmp_ofs_i | input | 26 | Signed relative-jump offset in bytes |
| pc_o | output | 32 | Current program counter |
| link_val_o | output | 32 | Return address (PC+4) for register 31 |
| link_we_o | output | 1 | Write enable for register 31 |

## Verification
The hardest cases to reach are the ones near the edges of the address space: wrap past 0xFFFFFFFF, and negative offsets that carry below address 0. Sequential steps from reset would take billions of cycles to get there. The bench instead uses a register jump to place the PC at any chosen address in one step, and then applies steps, branches and jumps from that point. Branches are run in pairs with a zero and a non-zero operand, using positive and negative offsets, so that both the taken and the fall-through paths of each condition are observed.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // Decoded control-flow kind; the code values are part of the port contract.
    typedef enum logic [2:0] {
        FK_SEQ       = 3'd0,
        FK_BR_ZERO   = 3'd1,
        FK_BR_NZERO  = 3'd2,
        FK_JREL      = 3'd3,
        FK_JREL_LINK = 3'd4,
        FK_JREG      = 3'd5,
        FK_JREG_LINK = 3'd6,
        FK_RSVD      = 3'd7
    } flow_kind_e;

    // Which source the next PC comes from.
    typedef enum logic [1:0] {
        SRC_SEQ = 2'd0,
        SRC_BR  = 2'd1,
        SRC_JMP = 2'd2,
        SRC_REG = 2'd3
    } pc_src_e;

endpackage

// File: rtl/pcu_decide.sv
module pcu_decide
    import pcu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        kind_i,
    input  logic [DATA_W-1:0] rs_val_i,
    output pc_src_e           src_o,
    output logic              link_o
);

    logic      rs_zero;
    flow_kind_e kind;

    assign kind    = flow_kind_e'(kind_i);
    assign rs_zero = (rs_val_i == '0);

    always_comb begin
        src_o  = SRC_SEQ;
        link_o = 1'b0;
        case (kind)
            FK_SEQ:       src_o = SRC_SEQ;
            FK_BR_ZERO:   src_o = rs_zero ? SRC_BR : SRC_SEQ;
            FK_BR_NZERO:  src_o = rs_zero ? SRC_SEQ : SRC_BR;
            FK_JREL:      src_o = SRC_JMP;
            FK_JREL_LINK: begin
                src_o  = SRC_JMP;
                link_o = 1'b1;
            end
            FK_JREG:      src_o = SRC_REG;
            FK_JREG_LINK: begin
                src_o  = SRC_REG;
                link_o = 1'b1;
            end
            FK_RSVD:      src_o = SRC_SEQ;
            default:      src_o = SRC_SEQ;
        endcase
    end

endmodule

// File: rtl/pcu_target.sv
module pcu_target #(
    parameter int ADDR_W = 32,
    parameter int BOFS_W = 16,
    parameter int JOFS_W = 26,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [BOFS_W-1:0] br_ofs_i,
    input  logic [JOFS_W-1:0] jmp_ofs_i,
    output logic [ADDR_W-1:0] seq_o,
    output logic [ADDR_W-1:0] br_tgt_o,
    output logic [ADDR_W-1:0] jmp_tgt_o
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    logic [ADDR_W-1:0] br_ext;
    logic [ADDR_W-1:0] jmp_ext;

    // Sign-extend each offset, or keep its low bits if the offset is as wide as an address.
    generate
        if (ADDR_W > BOFS_W) begin : g_br_ext
            assign br_ext = {{(ADDR_W-BOFS_W){br_ofs_i[BOFS_W-1]}}, br_ofs_i};
        end else begin : g_br_trunc
            assign br_ext = br_ofs_i[ADDR_W-1:0];
        end
        if (ADDR_W > JOFS_W) begin : g_j_ext
            assign jmp_ext = {{(ADDR_W-JOFS_W){jmp_ofs_i[JOFS_W-1]}}, jmp_ofs_i};
        end else begin : g_j_trunc
            assign jmp_ext = jmp_ofs_i[ADDR_W-1:0];
        end
    endgenerate

    // Relative targets are measured from the following instruction.
    assign seq_o     = pc_i + STEP_V;
    assign br_tgt_o  = seq_o + br_ext;
    assign jmp_tgt_o = seq_o + jmp_ext;

endmodule

// File: rtl/pcu_top.sv
module pcu_top
    import pcu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BOFS_W = 16,
    parameter int JOFS_W = 26,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv_i,
    input  logic [2:0]        kind_i,
    input  logic [ADDR_W-1:0] rs_val_i,
    input  logic [BOFS_W-1:0] br_ofs_i,
    input  logic [JOFS_W-1:0] jmp_ofs_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] link_val_o,
    output logic              link_we_o
);

    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pcu_state_t;

    pcu_state_t        st_d, st_q;
    pc_src_e           src;
    logic              link;
    logic [ADDR_W-1:0] seq_pc, br_pc, jmp_pc;

    pcu_decide #(
        .DATA_W (ADDR_W)
    ) u_decide (
        .kind_i   (kind_i),
        .rs_val_i (rs_val_i),
        .src_o    (src),
        .link_o   (link)
    );

    pcu_target #(
        .ADDR_W (ADDR_W),
        .BOFS_W (BOFS_W),
        .JOFS_W (JOFS_W),
        .STEP   (STEP)
    ) u_target (
        .pc_i      (st_q.pc),
        .br_ofs_i  (br_ofs_i),
        .jmp_ofs_i (jmp_ofs_i),
        .seq_o     (seq_pc),
        .br_tgt_o  (br_pc),
        .jmp_tgt_o (jmp_pc)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (adv_i) begin
            case (src)
                SRC_SEQ: st_d.pc = seq_pc;
                SRC_BR:  st_d.pc = br_pc;
                SRC_JMP: st_d.pc = jmp_pc;
                SRC_REG: st_d.pc = rs_val_i;
                default: st_d.pc = seq_pc;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o       = st_q.pc;
    assign link_val_o = seq_pc;
    assign link_we_o  = adv_i && link && !rst;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !adv_i |=> $stable(pc_o));                                           // R3
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv_i && (kind_i == 3'd0)) |=> (pc_o == $past(pc_o) + STEP_V));     // R2
    AST_REG_JUMP: assert property (@(posedge clk) disable iff (rst)
        (adv_i && (kind_i == 3'd5 || kind_i == 3'd6)) |=> (pc_o == $past(rs_val_i))); // R7
    AST_LINK_NEEDS_ADV: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> adv_i);                                                // R8
    AST_NO_LINK_PLAIN: assert property (@(posedge clk) disable iff (rst)
        (kind_i == 3'd1 || kind_i == 3'd2 || kind_i == 3'd3) |-> !link_we_o); // R9
    AST_BRZ_FALL: assert property (@(posedge clk) disable iff (rst)
        (adv_i && kind_i == 3'd1 && rs_val_i != '0) |=> (pc_o == $past(pc_o) + STEP_V)); // R4

endmodule

// File: tb/tb_pcu_top.sv
module tb_pcu_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        adv_i;
    logic [2:0]  kind_i;
    logic [31:0] rs_val_i;
    logic [15:0] br_ofs_i;
    logic [25:0] jmp_ofs_i;
    logic [31:0] pc_o;
    logic [31:0] link_val_o;
    logic        link_we_o;

    int total = 0;
    int bad   = 0;
    logic [31:0] model_pc;

    always #4 clk = ~clk;

    pcu_top dut (
        .clk        (clk),
        .rst        (rst),
        .adv_i      (adv_i),
        .kind_i     (kind_i),
        .rs_val_i   (rs_val_i),
        .br_ofs_i   (br_ofs_i),
        .jmp_ofs_i  (jmp_ofs_i),
        .pc_o       (pc_o),
        .link_val_o (link_val_o),
        .link_we_o  (link_we_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One advance: drive after a falling edge, check the link outputs, then the PC a cycle later.
    task automatic step(input logic [2:0] k, input logic [31:0] rs, input logic [15:0] b,
                        input logic [25:0] j, input string req);
        logic [31:0] seqv;
        logic [31:0] exp;
        logic        lnk;
        adv_i = 1'b1; kind_i = k; rs_val_i = rs; br_ofs_i = b; jmp_ofs_i = j;
        #1;
        seqv = model_pc + 32'd4;
        lnk  = (k == 3'd4) || (k == 3'd6);
        check({req, " link_we"}, {31'd0, link_we_o}, {31'd0, lnk});
        if (lnk) check({req, " link_val"}, link_val_o, seqv);
        case (k)
            3'd1:       exp = (rs == 0) ? seqv + {{16{b[15]}}, b} : seqv;
            3'd2:       exp = (rs != 0) ? seqv + {{16{b[15]}}, b} : seqv;
            3'd3, 3'd4: exp = seqv + {{6{j[25]}}, j};
            3'd5, 3'd6: exp = rs;
            default:    exp = seqv;
        endcase
        @(negedge clk);
        adv_i = 1'b0;
        model_pc = exp;
        check({req, " pc"}, pc_o, exp);
    endtask

    task automatic t_reset;
        rst = 1'b1; adv_i = 1'b1; kind_i = 3'd5; rs_val_i = 32'h1234_5678;
        br_ofs_i = '0; jmp_ofs_i = '0;
        repeat (3) @(negedge clk);
        check("R1 pc during reset", pc_o, 32'd0);
        check("R1 no link during reset", {31'd0, link_we_o}, 32'd0);
        rst = 1'b0; adv_i = 1'b0; kind_i = 3'd0;
        @(negedge clk);
        check("R1 pc after release", pc_o, 32'd0);
        model_pc = 32'd0;
        step(3'd0, 32'd0, 16'd0, 26'd0, "R1 first step");
    endtask

    task automatic t_seq;
        step(3'd0, 32'hFFFF_FFFF, 16'h7FFF, 26'h3FF_FFFF, "R2 seq");
        step(3'd0, 32'd0, 16'd0, 26'd0, "R2 seq again");
        step(3'd7, 32'd0, 16'h0100, 26'h100, "R2 code7 as seq");
    endtask

    task automatic t_hold;
        adv_i = 1'b0; kind_i = 3'd6; rs_val_i = 32'hDEAD_BEEC; jmp_ofs_i = 26'h40;
        #1;
        check("R3 link_we idle", {31'd0, link_we_o}, 32'd0);
        repeat (2) @(negedge clk);
        check("R3 pc held", pc_o, model_pc);
    endtask

    task automatic t_branch_zero;
        step(3'd1, 32'd0, 16'h0010, 26'd0, "R4 bz taken fwd");
        step(3'd1, 32'd5, 16'h0010, 26'd0, "R4 bz not taken");
        step(3'd1, 32'd0, 16'hFFF0, 26'd0, "R4 bz taken back");
    endtask

    task automatic t_branch_nzero;
        step(3'd2, 32'h8000_0000, 16'h0020, 26'd0, "R5 bnz taken");
        step(3'd2, 32'd0, 16'h0020, 26'd0, "R5 bnz not taken");
        step(3'd2, 32'd1, 16'hFFFC, 26'd0, "R5 bnz taken back");
    endtask

    task automatic t_jump_rel;
        step(3'd3, 32'd0, 16'd0, 26'h000_1000, "R6 jrel fwd");
        step(3'd3, 32'd0, 16'd0, 26'h3FF_F000, "R6 jrel back");
        step(3'd3, 32'd0, 16'd0, 26'h200_0000, "R6 jrel min");
    endtask

    task automatic t_jump_reg;
        step(3'd5, 32'h0040_0000, 16'h0004, 26'h4, "R7 jreg");
        step(3'd5, 32'h0000_0123, 16'd0, 26'd0, "R7 jreg unaligned");
    endtask

    task automatic t_link;
        step(3'd4, 32'd0, 16'd0, 26'h000_0100, "R8 jrel link");
        step(3'd6, 32'h0000_2000, 16'd0, 26'd0, "R8 jreg link");
    endtask

    task automatic t_no_link;
        step(3'd1, 32'd0, 16'd8, 26'd0, "R9 bz no link");
        step(3'd2, 32'd0, 16'd8, 26'd0, "R9 bnz no link");
        step(3'd3, 32'd0, 16'd0, 26'd8, "R9 jrel no link");
        step(3'd5, 32'h100, 16'd0, 26'd0, "R9 jreg no link");
        step(3'd7, 32'd0, 16'd0, 26'd0, "R9 code7 no link");
    endtask

    task automatic t_wrap;
        step(3'd5, 32'hFFFF_FFFC, 16'd0, 26'd0, "R10 place top");
        step(3'd0, 32'd0, 16'd0, 26'd0, "R10 seq wrap");
        step(3'd5, 32'h0000_0008, 16'd0, 26'd0, "R10 place low");
        step(3'd1, 32'd0, 16'hFFF0, 26'd0, "R10 branch under zero");
        step(3'd4, 32'd0, 16'd0, 26'h000_0010, "R10 link wrap");
    endtask

    initial begin : watchdog
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_pc = 32'd0;
        t_reset;
        t_seq;
        t_hold;
        t_branch_zero;
        t_branch_nzero;
        t_jump_rel;
        t_jump_reg;
        t_link;
        t_no_link;
        t_wrap;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule